// File: doc/BRIEF.md
# Serial Port Interrupt Flag Unit

This block collects the interrupt requests of one serial port into a small byte-addressed register set and drives a single interrupt line. There are two sources. Bit 0 is transmit and bit 1 is receive. Each source has a latched flag that a hardware event sets. Software can also set or clear the flag through two strobe addresses, where writing one to a bit sets or clears it. An enable register gates each source on its own. A read-only status view shows the flags that are both raised and enabled, and the interrupt line is asserted whenever any status bit is set.

The software set strobe lets a driver raise the receive interrupt on purpose. A driver needs this when bytes sit in the receive FIFO below the level at which the FIFO would raise the interrupt itself. The usual handler sequence is to read status, clear both flags through the clear strobe, and then service the sources that were pending. Drivers start and stop each source by read-modify-writing the enable register.

The transmit event is made inside the block from two FIFO level inputs. The receive event arrives as a one-cycle pulse from the receive FIFO logic.

Top module: `ser_irq_unit`

## Requirements
- R1: After reset all flags and enables are 0, `irq` is 0 and `rdata` is 0.
- R2: A write to address 0x1D sets every flag whose data bit is 1, with bit 0 for transmit and bit 1 for receive, even when no hardware event occurs.
- R3: Data bits written as 0 at address 0x1D or 0x1C leave the matching flag unchanged.
- R4: A write to address 0x1C clears every flag whose data bit is 1.
- R5: When a hardware event and a clear strobe hit the same flag in the same cycle, the flag ends up set.
- R6: A one-cycle pulse on `rx_evt` sets the receive flag (bit 1).
- R7: The transmit flag (bit 0) is set in the cycle in which `tx_full` falls, or in which `tx_almost` falls; a rising edge of either input sets nothing.
- R8: Address 0x1E holds the enable bits: bits 1:0 are writable and read back, and the upper bits read as 0.
- R9: Address 0x1F reads the flags ANDed with the enables, and `irq` is 1 exactly when that value is nonzero; a raised but disabled flag does not assert `irq`.
- R10: A read returns its data on `rdata` one clock after `rd_en`. Reads of 0x1C, 0x1D and any unmapped address return 0, and `rdata` is 0 in a cycle after which no read was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| tx_full | input | 1 | Transmit FIFO full level |
| tx_almost | input | 1 | Transmit FIFO at or above its almost-full level |
| rx_evt | input | 1 | Receive event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit address and data path and the four strobe and register offsets at 0x1C to 0x1F. With these values the exact addresses a driver uses can be reached. Unmapped neighbours such as 0x1B and 0x20 can also be read to confirm that they return 0. The bench drives the collision of a clear strobe with a receive pulse in a single cycle, and it drives a falling edge on each transmit level input as a separate case.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;
  localparam int NSRC    = 2;
  localparam int SRC_TX  = 0;
  localparam int SRC_RX  = 1;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_CLR, ACC_SET, ACC_EN, ACC_STAT
  } acc_e;

  // Next value of one flag: a hardware event dominates, then set, then clear.
  function automatic logic flag_next(logic cur, logic evt, logic set, logic clr);
    return evt | set | (cur & ~clr);
  endfunction

  // Masked status view of the flags.
  function automatic logic [NSRC-1:0] masked(logic [NSRC-1:0] f, logic [NSRC-1:0] e);
    return f & e;
  endfunction
endpackage

// File: rtl/ser_irq_txev.sv
module ser_irq_txev (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_full,
  input  logic tx_almost,
  output logic tx_evt
);
  logic full_q;
  logic almost_q;
  logic full_fell;
  logic almost_fell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      almost_q <= 1'b0;
    end else begin
      full_q   <= tx_full;
      almost_q <= tx_almost;
    end
  end

  assign full_fell   = full_q & ~tx_full;
  assign almost_fell = almost_q & ~tx_almost;
  assign tx_evt      = full_fell | almost_fell;

  // R7: an event only follows a real falling edge on one of the levels
  a_r7_evt_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |-> (($past(tx_full) && !tx_full) || ($past(tx_almost) && !tx_almost)));
endmodule

// File: rtl/ser_irq_flag.sv
module ser_irq_flag
  import ser_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_next(flag_o, evt_i, set_i, clr_i);
  end

  // R5: event wins over a simultaneous clear
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_o);
  // R2: software set raises the flag
  a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R4: a clear without event or set drops the flag
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i && !set_i) |=> !flag_o);
  // R3: no strobe and no event keeps the flag
  a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !evt_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/ser_irq_unit.sv
module ser_irq_unit
  import ser_irq_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  OFS_CLR = 8'h1C,
  parameter logic [7:0]  OFS_SET = 8'h1D,
  parameter logic [7:0]  OFS_EN  = 8'h1E,
  parameter logic [7:0]  OFS_ST  = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tx_full,
  input  logic              tx_almost,
  input  logic              rx_evt,
  output logic              irq
);
  localparam int PAD_W = DATA_W - NSRC;

  acc_e            acc;
  logic [NSRC-1:0] hw_evt;
  logic [NSRC-1:0] set_hit;
  logic [NSRC-1:0] clr_hit;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] stat;
  logic            tx_evt;
  logic            en_wr;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if (addr == ADDR_W'(OFS_CLR))      acc = ACC_CLR;
    else if (addr == ADDR_W'(OFS_SET)) acc = ACC_SET;
    else if (addr == ADDR_W'(OFS_EN))  acc = ACC_EN;
    else if (addr == ADDR_W'(OFS_ST))  acc = ACC_STAT;
    else                               acc = ACC_NONE;
  end

  ser_irq_txev u_txev (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_full   (tx_full),
    .tx_almost (tx_almost),
    .tx_evt    (tx_evt)
  );

  assign hw_evt[SRC_TX] = tx_evt;
  assign hw_evt[SRC_RX] = rx_evt;
  assign set_hit = (wr_en && acc == ACC_SET) ? wdata[NSRC-1:0] : '0;
  assign clr_hit = (wr_en && acc == ACC_CLR) ? wdata[NSRC-1:0] : '0;
  assign en_wr   = wr_en && acc == ACC_EN;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    ser_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (hw_evt[i]),
      .set_i  (set_hit[i]),
      .clr_i  (clr_hit[i]),
      .flag_o (flags[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wdata[NSRC-1:0];
  end

  assign stat = masked(flags, en_q);
  assign irq  = |stat;

  always_comb begin
    unique case (acc)
      ACC_EN:   rd_mux = {{PAD_W{1'b0}}, en_q};
      ACC_STAT: rd_mux = {{PAD_W{1'b0}}, stat};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_mux : '0;
  end

  // R8: enables change only through their own address
  a_r8_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));
  // R9: a disabled flag never drives the interrupt line
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(en_q & flags) > 0));
  // R10: strobe addresses read back as zero
  a_r10_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (acc == ACC_CLR || acc == ACC_SET)) |=> rdata == '0);
  // R10: no read, no data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == '0);
endmodule

// File: tb/ser_irq_unit_test.sv
module ser_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_full = 1'b0;
  logic       tx_almost = 1'b0;
  logic       rx_evt = 1'b0;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;
  logic pend = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  ser_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_full(tx_full), .tx_almost(tx_almost),
    .rx_evt(rx_evt), .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data one clock after each read
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check("scoreboard empty", 8'h00, 8'hFF);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  // Rough model of the flag state, independent of the design
  logic [1:0] m_flag = 2'b00;
  logic [1:0] m_en   = 2'b00;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq at reset", {7'd0, irq}, 8'h00);
    check("R1 rdata at reset", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h1E, 8'h00, "R1 enable reset");
    rd(8'h1F, 8'h00, "R1 status reset");

    // R8 enable register
    wr(8'h1E, 8'hFF); m_en = 2'b11;
    rd(8'h1E, 8'h03, "R8 enable readback upper zero");
    check("R9 no flags no irq", {7'd0, irq}, 8'h00);

    // R2 software set of receive only
    wr(8'h1D, 8'h02); m_flag = 2'b10;
    rd(8'h1F, 8'h02, "R2 set rx");
    check("R9 irq with rx", {7'd0, irq}, 8'h01);
    // R3 zero bits do nothing
    wr(8'h1D, 8'h00);
    rd(8'h1F, 8'h02, "R3 zero set");
    wr(8'h1C, 8'h01);
    rd(8'h1F, 8'h02, "R3 clear of other bit");
    // R2 set transmit
    wr(8'h1D, 8'h01); m_flag = 2'b11;
    rd(8'h1F, m_flag & m_en, "R2 set tx");
    // R9 masking
    wr(8'h1E, 8'h01); m_en = 2'b01;
    rd(8'h1F, 8'h01, "R9 masked status");
    wr(8'h1E, 8'h00); m_en = 2'b00;
    check("R9 disabled flags no irq", {7'd0, irq}, 8'h00);
    rd(8'h1F, 8'h00, "R9 all masked");
    wr(8'h1E, 8'h03); m_en = 2'b11;
    rd(8'h1F, 8'h03, "R9 re-enabled keeps flags");
    // R4 clear both
    wr(8'h1C, 8'h03); m_flag = 2'b00;
    rd(8'h1F, 8'h00, "R4 clear both");
    check("R4 irq after clear", {7'd0, irq}, 8'h00);

    // R6 receive pulse
    @(negedge clk); rx_evt = 1'b1;
    @(negedge clk); rx_evt = 1'b0;
    rd(8'h1F, 8'h02, "R6 rx pulse");

    // R5 collision: clear both while rx pulses
    wr(8'h1D, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h1C; wdata = 8'h03; rx_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rx_evt = 1'b0;
    rd(8'h1F, 8'h02, "R5 event beats clear");
    wr(8'h1C, 8'h03);

    // R7 rising tx_full sets nothing, falling sets tx
    @(negedge clk); tx_full = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h1F, 8'h00, "R7 rising full ignored");
    tx_full = 1'b0;
    @(negedge clk);
    rd(8'h1F, 8'h01, "R7 full fell");
    wr(8'h1C, 8'h01);
    @(negedge clk); tx_almost = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h1F, 8'h00, "R7 rising almost ignored");
    tx_almost = 1'b0;
    @(negedge clk);
    rd(8'h1F, 8'h01, "R7 almost fell");

    // R10 strobe and unmapped reads
    rd(8'h1C, 8'h00, "R10 clear addr reads zero");
    rd(8'h1D, 8'h00, "R10 set addr reads zero");
    rd(8'h1B, 8'h00, "R10 unmapped below");
    rd(8'h20, 8'h00, "R10 unmapped above");
    @(negedge clk);
    check("R10 idle rdata", rdata, 8'h00);

    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule